// File: doc/BRIEF.md
# Dual-Port Address Collision Detector

This block watches the two access ports of a dual-port memory. Both ports run on one shared clock. In every cycle it compares the internal addresses of the two ports, which come from their address counters. When both ports are selected and their addresses are equal, the access pair can corrupt the stored word or return stale data. The block then raises an active-low collision pulse on each port whose data is at risk.

A port that reads while the other port writes the same word is the one that gets the flag. When both ports write the same word, both ports are flagged. Two reads of the same word are harmless, so neither port is flagged.

Each flag travels through a short shift pipeline of per-port bits. A flag comes out a fixed number of clock edges (parameter `LAT`, default 2) after the access is sampled. It lasts exactly one cycle per colliding access. The memory array itself and output-enable handling live outside this block.

Top module: `dp_clash_detect`

## Requirements
- R1: When both selected ports read the same address (`*_wr_n` = 1), neither `lt_clash_n` nor `rt_clash_n` goes low.
- R2: When the left port reads and the right port writes (`rt_wr_n` = 0) the same address, only `lt_clash_n` goes low.
- R3: When the right port reads and the left port writes (`lt_wr_n` = 0) the same address, only `rt_clash_n` goes low.
- R4: When both ports write the same address, both `lt_clash_n` and `rt_clash_n` go low.
- R5: A port is selected only when its `*_sel0_n` is 0 and its `*_sel1` is 1. If either port is not selected, no flag is raised on either output, whatever the addresses and write controls are.
- R6: Addresses are compared over all `ADDR_W` bits. Two addresses that differ only in the most significant bit raise no flag.
- R7: An access sampled at a clock edge drives its flag low after the `LAT`-th edge, counting the sampling edge as the first. After the first edge alone, the outputs are still high.
- R8: Each flag lasts one cycle and then returns high unless a later collision arrives. Collisions on consecutive cycles give consecutive low cycles, each showing its own pattern of ports.
- R9: While the synchronous reset `rst` is high at a clock edge, both outputs are high after that edge. Any flag still in the pipeline is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared clock of both ports |
| rst | input | 1 | Synchronous reset, active high |
| lt_addr | input | ADDR_W | Left port internal (counter) address |
| lt_wr_n | input | 1 | Left port write, active low (1 = read) |
| lt_sel0_n | input | 1 | Left port select, active low |
| lt_sel1 | input | 1 | Left port select, active high |
| rt_addr | input | ADDR_W | Right port internal (counter) address |
| rt_wr_n | input | 1 | Right port write, active low (1 = read) |
| rt_sel0_n | input | 1 | Right port select, active low |
| rt_sel1 | input | 1 | Right port select, active high |
| lt_clash_n | output | 1 | Left port collision flag, active low |
| rt_clash_n | output | 1 | Right port collision flag, active low |

## Verification
Two things can land in the same cycle: the end of one collision pulse and the start of the next, or a flag in flight and a reset. The first case is provoked by a write-write clash followed at once by a read-write clash. The bench checks that the outputs go from both-low straight to left-only-low and then high, with no high cycle between the two pulses. The second case is provoked by raising reset one cycle after a clash. The bench checks that the flag never appears and that the outputs stay high after reset is released.

// File: rtl/dp_clash_detect.sv
module dp_clash_detect #(
  parameter int ADDR_W = 18,
  parameter int LAT    = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] lt_addr,
  input  logic              lt_wr_n,
  input  logic              lt_sel0_n,
  input  logic              lt_sel1,
  input  logic [ADDR_W-1:0] rt_addr,
  input  logic              rt_wr_n,
  input  logic              rt_sel0_n,
  input  logic              rt_sel1,
  output logic              lt_clash_n,
  output logic              rt_clash_n
);
  localparam int STG = (LAT < 1) ? 1 : LAT;

  logic lt_on, rt_on, same, lt_hit, rt_hit;
  logic [1:0] pipe [STG];

  assign lt_on  = ~lt_sel0_n & lt_sel1;
  assign rt_on  = ~rt_sel0_n & rt_sel1;
  assign same   = lt_on & rt_on & (lt_addr == rt_addr);
  assign lt_hit = same & ~rt_wr_n;
  assign rt_hit = same & ~lt_wr_n;

  for (genvar g = 0; g < STG; g++) begin : g_stage
    if (g == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (rst) pipe[g] <= '0;
        else     pipe[g] <= {lt_hit, rt_hit};
      end
    end else begin : g_tail
      always_ff @(posedge clk) begin
        if (rst) pipe[g] <= '0;
        else     pipe[g] <= pipe[g-1];
      end
    end
  end

  assign lt_clash_n = ~pipe[STG-1][1];
  assign rt_clash_n = ~pipe[STG-1][0];
endmodule

// File: rtl/dp_clash_detect_chk.sv
module dp_clash_detect_chk #(
  parameter int ADDR_W = 18,
  parameter int LAT    = 2
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] lt_addr,
  input logic              lt_wr_n,
  input logic              lt_sel0_n,
  input logic              lt_sel1,
  input logic [ADDR_W-1:0] rt_addr,
  input logic              rt_wr_n,
  input logic              rt_sel0_n,
  input logic              rt_sel1,
  input logic              lt_clash_n,
  input logic              rt_clash_n
);
  logic [1:0] warm;
  always_ff @(posedge clk) begin
    if (rst) warm <= '0;
    else if (warm != 2'd3) warm <= warm + 2'd1;
  end

  logic eq, lsel, rsel;
  assign eq   = (lt_addr == rt_addr);
  assign lsel = !lt_sel0_n && lt_sel1;
  assign rsel = !rt_sel0_n && rt_sel1;

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (lt_clash_n && rt_clash_n)); // R9

  if (LAT == 2) begin : g_lat2
    AST_READ_READ_QUIET: assert property (@(posedge clk) disable iff (rst)
      (warm >= 2'd2 && $past(lsel && rsel && eq && lt_wr_n && rt_wr_n, 2))
      |-> (lt_clash_n && rt_clash_n)); // R1
    AST_LEFT_READER_FLAG: assert property (@(posedge clk) disable iff (rst)
      (warm >= 2'd2 && $past(lsel && rsel && eq && lt_wr_n && !rt_wr_n, 2))
      |-> (!lt_clash_n && rt_clash_n)); // R2
    AST_RIGHT_READER_FLAG: assert property (@(posedge clk) disable iff (rst)
      (warm >= 2'd2 && $past(lsel && rsel && eq && !lt_wr_n && rt_wr_n, 2))
      |-> (lt_clash_n && !rt_clash_n)); // R3
    AST_WRITE_WRITE_BOTH: assert property (@(posedge clk) disable iff (rst)
      (warm >= 2'd2 && $past(lsel && rsel && eq && !lt_wr_n && !rt_wr_n, 2))
      |-> (!lt_clash_n && !rt_clash_n)); // R4
    AST_UNSELECTED_QUIET: assert property (@(posedge clk) disable iff (rst)
      (warm >= 2'd2 && $past(!(lsel && rsel), 2))
      |-> (lt_clash_n && rt_clash_n)); // R5
    AST_ADDR_MISS_QUIET: assert property (@(posedge clk) disable iff (rst)
      (warm >= 2'd2 && $past(!eq, 2))
      |-> (lt_clash_n && rt_clash_n)); // R6
  end
endmodule

bind dp_clash_detect dp_clash_detect_chk #(.ADDR_W(ADDR_W), .LAT(LAT)) u_chk (
  .clk(clk), .rst(rst),
  .lt_addr(lt_addr), .lt_wr_n(lt_wr_n), .lt_sel0_n(lt_sel0_n), .lt_sel1(lt_sel1),
  .rt_addr(rt_addr), .rt_wr_n(rt_wr_n), .rt_sel0_n(rt_sel0_n), .rt_sel1(rt_sel1),
  .lt_clash_n(lt_clash_n), .rt_clash_n(rt_clash_n)
);

// File: tb/dp_clash_detect_bench.sv
`timescale 1ns/1ps
module dp_clash_detect_bench;
  localparam int AW = 18;

  logic clk = 1'b0;
  logic rst;
  logic [AW-1:0] lt_addr, rt_addr;
  logic lt_wr_n, lt_sel0_n, lt_sel1, rt_wr_n, rt_sel0_n, rt_sel1;
  logic lt_clash_n, rt_clash_n;
  int vectors = 0;
  int errs = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dp_clash_detect #(.ADDR_W(AW), .LAT(2)) u_dp_clash_detect (
    .clk(clk), .rst(rst),
    .lt_addr(lt_addr), .lt_wr_n(lt_wr_n), .lt_sel0_n(lt_sel0_n), .lt_sel1(lt_sel1),
    .rt_addr(rt_addr), .rt_wr_n(rt_wr_n), .rt_sel0_n(rt_sel0_n), .rt_sel1(rt_sel1),
    .lt_clash_n(lt_clash_n), .rt_clash_n(rt_clash_n)
  );

  task automatic chk(string req, logic el, logic er);
    vectors++;
    if (lt_clash_n !== el || rt_clash_n !== er) begin
      errs++;
      $display("FAIL %s: got lt=%b rt=%b expected lt=%b rt=%b", req, lt_clash_n, rt_clash_n, el, er);
    end
  endtask

  task automatic idle();
    lt_sel0_n = 1'b1; lt_sel1 = 1'b0; rt_sel0_n = 1'b1; rt_sel1 = 1'b0;
    lt_wr_n = 1'b1; rt_wr_n = 1'b1;
    lt_addr = '0; rt_addr = '0;
  endtask

  task automatic put(logic [AW-1:0] la, logic lw, logic ls0, logic ls1,
                     logic [AW-1:0] ra, logic rw, logic rs0, logic rs1);
    lt_addr = la; lt_wr_n = lw; lt_sel0_n = ls0; lt_sel1 = ls1;
    rt_addr = ra; rt_wr_n = rw; rt_sel0_n = rs0; rt_sel1 = rs1;
  endtask

  // One access, then idle; checks before, at and after the flag cycle.
  task automatic one_access(string req, logic [AW-1:0] la, logic lw, logic ls0, logic ls1,
                            logic [AW-1:0] ra, logic rw, logic rs0, logic rs1,
                            logic el, logic er);
    @(negedge clk); put(la, lw, ls0, ls1, ra, rw, rs0, rs1);
    @(negedge clk); idle(); chk({req, "/R7 early"}, 1'b1, 1'b1);
    @(negedge clk); chk(req, el, er);
    @(negedge clk); chk({req, "/R8 release"}, 1'b1, 1'b1);
  endtask

  task automatic test_reset_state();
    rst = 1'b1; idle();
    repeat (3) @(negedge clk);
    chk("R9 reset state", 1'b1, 1'b1);
    rst = 1'b0;
    @(negedge clk); chk("R9 after release", 1'b1, 1'b1);
  endtask

  task automatic test_read_read();
    one_access("R1 read-read", 18'h00123, 1, 0, 1, 18'h00123, 1, 0, 1, 1'b1, 1'b1);
  endtask

  task automatic test_left_reader();
    one_access("R2 left reads, right writes", 18'h3FFFF, 1, 0, 1, 18'h3FFFF, 0, 0, 1, 1'b0, 1'b1);
  endtask

  task automatic test_right_reader();
    one_access("R3 left writes, right reads", 18'h00000, 0, 0, 1, 18'h00000, 1, 0, 1, 1'b1, 1'b0);
  endtask

  task automatic test_write_write();
    one_access("R4 write-write", 18'h2A5A5, 0, 0, 1, 18'h2A5A5, 0, 0, 1, 1'b0, 1'b0);
  endtask

  task automatic test_unselected();
    one_access("R5 left sel0_n high", 18'h00040, 0, 1, 1, 18'h00040, 0, 0, 1, 1'b1, 1'b1);
    one_access("R5 right sel1 low", 18'h00040, 0, 0, 1, 18'h00040, 0, 0, 0, 1'b1, 1'b1);
  endtask

  task automatic test_addr_miss();
    one_access("R6 msb differs", 18'h00007, 0, 0, 1, 18'h20007, 0, 0, 1, 1'b1, 1'b1);
  endtask

  task automatic test_back_to_back();
    @(negedge clk); put(18'h00055, 0, 0, 1, 18'h00055, 0, 0, 1);
    @(negedge clk); put(18'h00056, 1, 0, 1, 18'h00056, 0, 0, 1);
    chk("R7 first still pending", 1'b1, 1'b1);
    @(negedge clk); idle(); chk("R8 first pulse both", 1'b0, 1'b0);
    @(negedge clk); chk("R8 second pulse left only", 1'b0, 1'b1);
    @(negedge clk); chk("R8 release after pair", 1'b1, 1'b1);
  endtask

  task automatic test_reset_in_flight();
    @(negedge clk); put(18'h01111, 0, 0, 1, 18'h01111, 0, 0, 1);
    @(negedge clk); idle(); rst = 1'b1;
    @(negedge clk); chk("R9 flag dropped by reset", 1'b1, 1'b1);
    rst = 1'b0;
    @(negedge clk); chk("R9 quiet after release", 1'b1, 1'b1);
  endtask

  initial begin
    test_reset_state();
    test_read_read();
    test_left_reader();
    test_right_reader();
    test_write_write();
    test_unselected();
    test_addr_miss();
    test_back_to_back();
    test_reset_in_flight();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
      $finish;
    end
  end

  initial begin
    #20000;
    if (!done) begin
      done = 1;
      errs++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
      $finish;
    end
  end
endmodule